// File: doc/BRIEF.md
# Two-Wire Slave Register Memory with Wiper Outputs

This block is a two-wire bus slave that sits in front of a 256-byte register space. A host addresses it with a seven-bit device address made of a fixed type code and three strap inputs, so up to eight of these blocks can share one bus. The host can write bytes, read back from the current pointer, do a random read by writing a word address and then issuing a repeated START, and read a run of bytes in sequence. The pointer wraps from FFh to 00h.

The space has three parts. Bytes 00h–F7h are general storage. F8h sets the position of a 100-step potentiometer and F9h sets the position of a 256-step potentiometer; both positions appear on output ports. Bytes FAh–FFh are reserved. A write-lock input stops writes to both the storage and the wiper registers. After each write transaction the block stays busy for a configurable number of system clocks, which stands in for a nonvolatile programming cycle. SCL and SDA are oversampled by the system clock through synchronizers. SDA is modelled as open drain: an output enables the low drive, and the resolved line is fed back in.

Top module: `twire_pot_mem`

## Requirements
- R1: After reset and after any STOP (SDA rising while SCL is high), `sda_oe` is 0 and the slave waits for a START (SDA falling while SCL is high).
- R2: The slave acknowledges only an address byte whose upper seven bits, MSB first, are type code 1010 followed by `strap[2:0]`. Bit 0 is read (1) or write (0). On a mismatch it does not acknowledge that byte or any later byte until the next START, and it stores nothing.
- R3: A write transaction is START, address with bit 0 = 0, word address, one or more data bytes, then STOP. Each byte is acknowledged, each data byte is stored at the pointer, and the pointer then advances by one.
- R4: A random read is an address write, a word-address byte, a repeated START, and an address with bit 0 = 1. The slave then sends the byte at that word address, MSB first.
- R5: While the host acknowledges, the slave keeps sending bytes from successive addresses, wrapping from FFh to 00h. A current-address read starts at the byte after the last one accessed.
- R6: When the host does not acknowledge a read byte, the slave releases SDA (`sda_oe` = 0) and sends nothing more.
- R7: While `wr_lock` is 1, writes are still acknowledged but change neither the storage, nor either wiper register, nor either wiper output.
- R8: A write to F8h drives `wiper_a` with the written value, saturated at 99. A write to F9h drives `wiper_b` with the written value. Reading F8h or F9h returns the byte as written. Both wipers reset to 0.
- R9: Writes to FAh–FFh have no effect, and reads of FAh–FFh return 00h.
- R10: A STOP that ends a transaction in which at least one data byte was stored starts a busy period of `WCYC` system clocks. During that period the slave does not acknowledge its address and keeps `sda_oe` at 0.
- R11: `sda_oe` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Resolved bus data line |
| sda_oe | output | 1 | When 1, the slave pulls SDA low |
| strap | input | 3 | Device address strap bits |
| wr_lock | input | 1 | When 1, blocks all stores |
| wiper_a | output | 7 | Position of the 100-step wiper, 0 to 99 |
| wiper_b | output | 8 | Position of the 256-step wiper |

## Verification
On every cycle, the assertions check that SDA drive changes only while SCL is low, that SDA is released after a STOP and throughout a busy period, that `wiper_a` never exceeds 99, and that both wipers hold still while the lock is set. Only the bench scenarios can show whether the right data comes back. These cover address matching and ignored transfers, random and current-address reads, pointer wrap across the reserved bytes, wiper saturation against the stored byte, refused addresses while busy, and stores blocked by the lock. All of these depend on byte sequences across whole transactions.

// File: rtl/twp_pkg.sv
package twp_pkg;
  localparam int          BYTE_W   = 8;
  localparam logic [7:0]  WIPA_LOC = 8'hF8;
  localparam logic [7:0]  WIPB_LOC = 8'hF9;

  typedef enum logic [2:0] {
    S_IDLE, S_DEV, S_WADR, S_WDAT, S_ACK, S_RDAT, S_RACK
  } bus_st_t;

  typedef enum logic [1:0] {
    RG_USER, RG_WA, RG_WB, RG_RSV
  } region_t;
endpackage

// File: rtl/twp_sync.sv
module twp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic q,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '1;
      prev <= 1'b1;
    end else begin
      sh   <= {sh[STAGES-2:0], din};
      prev <= sh[STAGES-1];
    end
  end

  assign q    = sh[STAGES-1];
  assign rise = q & ~prev;
  assign fall = ~q & prev;
endmodule

// File: rtl/twp_regs.sv
module twp_regs
  import twp_pkg::*;
#(
  parameter  int WIPA_POS = 100,
  localparam int WA_W     = $clog2(WIPA_POS),
  localparam int DEPTH    = 1 << BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [BYTE_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  output logic [WA_W-1:0]   wiper_a,
  output logic [BYTE_W-1:0] wiper_b
);
  logic [BYTE_W-1:0] mem [0:DEPTH-1];
  logic [BYTE_W-1:0] mem_q, wa_raw;
  region_t           sel_q;

  // storage array kept free of reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (we && addr < WIPA_LOC) mem[addr] <= wdata;
    mem_q <= mem[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= RG_RSV;
      wa_raw  <= '0;
      wiper_a <= '0;
      wiper_b <= '0;
    end else begin
      if (addr < WIPA_LOC)       sel_q <= RG_USER;
      else if (addr == WIPA_LOC) sel_q <= RG_WA;
      else if (addr == WIPB_LOC) sel_q <= RG_WB;
      else                       sel_q <= RG_RSV;
      if (we && addr == WIPA_LOC) begin
        wa_raw  <= wdata;
        wiper_a <= (wdata > BYTE_W'(WIPA_POS - 1)) ? WA_W'(WIPA_POS - 1)
                                                    : wdata[WA_W-1:0];
      end
      if (we && addr == WIPB_LOC) wiper_b <= wdata;
    end
  end

  always_comb begin
    case (sel_q)
      RG_USER: rdata = mem_q;
      RG_WA:   rdata = wa_raw;
      RG_WB:   rdata = wiper_b;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/twire_pot_mem.sv
module twire_pot_mem
  import twp_pkg::*;
#(
  parameter  int         WCYC        = 500000,
  parameter  logic [3:0] DEV_TYPE    = 4'b1010,
  parameter  int         WIPA_POS    = 100,
  parameter  int         SYNC_STAGES = 2,
  localparam int         WA_W        = $clog2(WIPA_POS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        strap,
  input  logic              wr_lock,
  output logic [WA_W-1:0]   wiper_a,
  output logic [BYTE_W-1:0] wiper_b
);
  localparam int BW = $clog2(WCYC + 1);

  logic [1:0] pin_in, pin_q, pin_r, pin_f;
  assign pin_in = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    twp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .din(pin_in[g]),
      .q(pin_q[g]), .rise(pin_r[g]), .fall(pin_f[g])
    );
  end

  logic scl_q, sda_q, scl_rise, scl_fall, start_c, stop_c;
  assign scl_q    = pin_q[1];
  assign sda_q    = pin_q[0];
  assign scl_rise = pin_r[1];
  assign scl_fall = pin_f[1];
  assign start_c  = pin_f[0] & scl_q;
  assign stop_c   = pin_r[0] & scl_q;

  bus_st_t           st, nxt;
  logic [3:0]        cnt;
  logic [BYTE_W-1:0] shreg, ptr, rd_byte;
  logic [6:0]        txsh;
  logic              more, wrote;
  logic [BW-1:0]     busy_cnt;
  logic              busy, we;

  assign busy = (busy_cnt != '0);
  assign we   = (st == S_WDAT) && scl_fall && (cnt == 4'd8) && !wr_lock;

  twp_regs #(.WIPA_POS(WIPA_POS)) u_regs (
    .clk(clk), .rst(rst), .we(we), .addr(ptr), .wdata(shreg),
    .rdata(rd_byte), .wiper_a(wiper_a), .wiper_b(wiper_b)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      nxt      <= S_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      txsh     <= '0;
      ptr      <= '0;
      more     <= 1'b0;
      wrote    <= 1'b0;
      busy_cnt <= '0;
      sda_oe   <= 1'b0;
    end else begin
      if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (start_c) begin
        st     <= S_DEV;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
        if (wrote) begin
          busy_cnt <= BW'(WCYC);
          wrote    <= 1'b0;
        end
      end else begin
        case (st)
          S_DEV, S_WADR, S_WDAT: begin
            if (scl_rise && cnt < 4'd8) begin
              shreg <= {shreg[6:0], sda_q};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              if (st == S_DEV) begin
                if (shreg[7:1] == {DEV_TYPE, strap} && !busy) begin
                  sda_oe <= 1'b1;
                  nxt    <= shreg[0] ? S_RDAT : S_WADR;
                  st     <= S_ACK;
                end else begin
                  st <= S_IDLE;
                end
              end else begin
                if (st == S_WADR) ptr <= shreg;
                else begin
                  ptr <= ptr + 1'b1;
                  if (!wr_lock) wrote <= 1'b1;
                end
                sda_oe <= 1'b1;
                nxt    <= S_WDAT;
                st     <= S_ACK;
              end
            end
          end
          S_ACK: if (scl_fall) begin
            if (nxt == S_RDAT) begin
              txsh   <= rd_byte[6:0];
              sda_oe <= ~rd_byte[7];
              cnt    <= '0;
            end else begin
              sda_oe <= 1'b0;
            end
            st <= nxt;
          end
          S_RDAT: if (scl_fall) begin
            if (cnt == 4'd7) begin
              sda_oe <= 1'b0;
              ptr    <= ptr + 1'b1;
              cnt    <= '0;
              st     <= S_RACK;
            end else begin
              cnt    <= cnt + 1'b1;
              sda_oe <= ~txsh[6];
              txsh   <= {txsh[5:0], 1'b0};
            end
          end
          S_RACK: begin
            if (scl_rise) more <= ~sda_q;
            if (scl_fall) begin
              if (more) begin
                txsh   <= rd_byte[6:0];
                sda_oe <= ~rd_byte[7];
                st     <= S_RDAT;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twp_chk.sv
module twp_chk #(
  parameter int WA_W   = 7,
  parameter int WA_MAX = 99
) (
  input logic            clk,
  input logic            rst,
  input logic            scl_q,
  input logic            sda_oe,
  input logic            busy,
  input logic            stop_c,
  input logic            wr_lock,
  input logic [WA_W-1:0] wiper_a,
  input logic [7:0]      wiper_b
);
  // R11
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !$past(scl_q));
  // R1
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_c |=> !sda_oe);
  // R10
  busy_silent_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_oe);
  // R8
  wiper_sat_chk: assert property (@(posedge clk) disable iff (rst)
    wiper_a <= WA_W'(WA_MAX));
  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    wr_lock |=> $stable(wiper_a) && $stable(wiper_b));
endmodule

bind twire_pot_mem twp_chk #(.WA_W(WA_W), .WA_MAX(WIPA_POS - 1)) u_twp_chk (
  .clk(clk), .rst(rst), .scl_q(scl_q), .sda_oe(sda_oe), .busy(busy),
  .stop_c(stop_c), .wr_lock(wr_lock), .wiper_a(wiper_a), .wiper_b(wiper_b)
);

// File: tb/test_twire_pot_mem.sv
module test_twire_pot_mem;
  localparam int         WCYC  = 300;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [3:0] TYPEC = 4'b1010;

  logic clk = 1'b0, rst = 1'b1, scl_m = 1'b1, sda_m = 1'b1, wr_lock = 1'b0;
  logic sda_oe, sda_line;
  logic [2:0] strap = STRAP;
  logic [6:0] wiper_a;
  logic [7:0] wiper_b;
  assign sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  twire_pot_mem #(.WCYC(WCYC)) i_twire_pot_mem (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap(strap), .wr_lock(wr_lock), .wiper_a(wiper_a), .wiper_b(wiper_b)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] mdl [0:247];
  logic [7:0] wa_m = 8'h00, wb_m = 8'h00, ptr_m = 8'h00;
  bit         vld [0:247];

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    if (a < 8'hF8) return mdl[a];
    if (a == 8'hF8) return wa_m;
    if (a == 8'hF9) return wb_m;
    return 8'h00;
  endfunction

  function automatic logic [6:0] exp_wa();
    return (wa_m > 8'd99) ? 7'd99 : wa_m[6:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1; w(5); scl_m = 1; w(10); sda_m = 0; w(10); scl_m = 0; w(5);
  endtask

  task automatic bus_stop();
    sda_m = 0; w(5); scl_m = 1; w(10); sda_m = 1; w(10);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; w(5); scl_m = 1; w(10); scl_m = 0; w(5);
    end
    sda_m = 1; w(5); scl_m = 1; w(5); ack = (sda_line == 1'b0); w(5);
    scl_m = 0; w(5);
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      w(5); scl_m = 1; w(5); b[i] = sda_line; w(5); scl_m = 0;
    end
    sda_m = ack ? 1'b0 : 1'b1; w(5); scl_m = 1; w(10); scl_m = 0;
    sda_m = 1; w(5);
  endtask

  task automatic wr_nowait(input logic [7:0] a, input logic [7:0] d, input string tag);
    bit ack;
    bus_start();
    send_byte({TYPEC, STRAP, 1'b0}, ack); chk(ack, tag, ack, 1);
    send_byte(a, ack);                   chk(ack, tag, ack, 1);
    send_byte(d, ack);                   chk(ack, tag, ack, 1);
    bus_stop();
    if (!wr_lock) begin
      if (a < 8'hF8) begin mdl[a] = d; vld[a] = 1; end
      else if (a == 8'hF8) wa_m = d;
      else if (a == 8'hF9) wb_m = d;
    end
    ptr_m = a + 8'd1;
  endtask

  task automatic wr_one(input logic [7:0] a, input logic [7:0] d, input string tag);
    wr_nowait(a, d, tag);
    w(WCYC + 30);
  endtask

  task automatic rd_run(input bit rnd, input logic [7:0] a, input int n, input string tag);
    bit ack;
    logic [7:0] b, ex;
    bus_start();
    if (rnd) begin
      send_byte({TYPEC, STRAP, 1'b0}, ack);
      send_byte(a, ack);
      bus_start();
      ptr_m = a;
    end
    send_byte({TYPEC, STRAP, 1'b1}, ack); chk(ack, tag, ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, b);
      ex = exp_rd(ptr_m);
      chk(b === ex, tag, b, ex);
      ptr_m = ptr_m + 8'd1;
    end
    chk(sda_oe == 1'b0, "R6 release after host NACK", sda_oe, 0);
    bus_stop();
    chk(sda_oe == 1'b0, "R1 released after STOP", sda_oe, 0);
  endtask

  initial begin
    bit ack;
    logic [7:0] a;
    void'($urandom(32'd1845));
    w(5); rst = 0; w(5);

    // R1 R8 reset state
    chk(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
    chk(wiper_a == 7'd0 && wiper_b == 8'd0, "R8 reset wipers", {wiper_a, wiper_b}, 0);

    wr_one(8'h00, 8'h5A, "R3");
    wr_one(8'h01, 8'hC3, "R3");
    wr_one(8'h02, 8'h11, "R3");
    rd_run(1, 8'h00, 1, "R4 random read");

    // R8 wipers
    wr_one(8'hF8, 8'd150, "R8");
    chk(wiper_a == exp_wa(), "R8 saturate at 99", wiper_a, exp_wa());
    rd_run(1, 8'hF8, 1, "R8 read raw byte");
    wr_one(8'hF8, 8'd42, "R8");
    chk(wiper_a == 7'd42, "R8 wiper_a value", wiper_a, 42);
    wr_one(8'hF9, 8'd200, "R8");
    chk(wiper_b == 8'd200, "R8 wiper_b value", wiper_b, 200);

    // R9 reserved bytes
    wr_one(8'hFC, 8'h77, "R9");
    rd_run(1, 8'hFC, 1, "R9 reserved reads 00");

    // R5 wrap FE FF 00 01, then current-address read continues at 02
    rd_run(1, 8'hFE, 4, "R5 sequential wrap");
    rd_run(0, 8'h00, 1, "R5 current address");

    // R2 address mismatch: wrong strap, then wrong type code
    bus_start();
    send_byte({TYPEC, STRAP ^ 3'b010, 1'b0}, ack);
    chk(!ack, "R2 strap mismatch NACK", ack, 0);
    send_byte(8'h00, ack); chk(!ack, "R2 ignored after mismatch", ack, 0);
    send_byte(8'hEE, ack); chk(!ack, "R2 ignored after mismatch", ack, 0);
    bus_stop();
    bus_start();
    send_byte({4'b1011, STRAP, 1'b1}, ack);
    chk(!ack, "R2 type mismatch NACK", ack, 0);
    bus_stop();
    rd_run(1, 8'h00, 1, "R2 nothing stored on mismatch");

    // R7 write lock
    wr_lock = 1;
    wr_one(8'h00, 8'hFF, "R7");
    wr_one(8'hF9, 8'h01, "R7");
    wr_one(8'hF8, 8'h05, "R7");
    chk(wiper_b == 8'd200 && wiper_a == 7'd42, "R7 wipers held", {wiper_a, wiper_b}, {7'd42, 8'd200});
    wr_lock = 0;
    rd_run(1, 8'h00, 1, "R7 storage held");

    // R10 busy period
    wr_nowait(8'h03, 8'h44, "R3");
    bus_start();
    send_byte({TYPEC, STRAP, 1'b1}, ack);
    chk(!ack, "R10 NACK while busy", ack, 0);
    bus_stop();
    w(WCYC + 30);
    bus_start();
    send_byte({TYPEC, STRAP, 1'b0}, ack);
    chk(ack, "R10 ACK after busy", ack, 1);
    bus_stop();
    w(10);

    // R3 random stores and reads
    for (int k = 0; k < 16; k++) begin
      a = 8'($urandom_range(3, 247));
      wr_lock = ($urandom_range(0, 3) == 0);
      wr_one(a, 8'($urandom), "R3");
      wr_lock = 0;
    end
    for (int k = 0; k < 16; k++) begin
      a = 8'($urandom_range(0, 247));
      if (vld[a]) rd_run(1, a, 2, "R3 random readback");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule